// File: doc/BRIEF.md
# CAN Receive Bit Sampler

This block turns an oversampled CAN receive line into a stream of bit decisions. While idle it watches the line for a dominant level (logic 0), which it treats as the start of a frame. From that point it produces one sample per bit, taken a programmable number of clock cycles into each bit time. Each sample is reported as a one-cycle `bitValid` strobe, and `bitValue` carries the sampled level.

The timing reference is re-anchored on every recessive-to-dominant transition seen during reception. This lets the sampler follow a transmitter whose bit rate drifts slightly from the programmed one. Two bit timings are supplied as cycle counts, a nominal one and a fast one, and `rateFast` picks between them at run time so that flexible-data-rate frames can be followed. Downstream frame logic, which decides when to switch rates, raises `frameDone` to return the sampler to idle.

The bit position is held as a countdown, not as an absolute time. The result is the same as placing sample n at anchor time + period × (n − anchor bit index) + offset, and no multiplier is needed. The line input is assumed to be already synchronous to `clk`.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset `bitValid` and `bitValue` are 0, and the block is idle.
- R2: While idle, if `rxLine` is 0 at clock edge k, the first sample is taken at edge k+O (O = selected offset, 1 ≤ O < P). `bitValid` is 1 for the cycle after that edge, and `bitValue` is the `rxLine` level seen at that edge.
- R3: Without anchor events, each following sample comes P cycles after the previous one (P = selected period, P ≥ 2).
- R4: `bitValid` is never high in two consecutive cycles, and `bitValue` changes only when a sample is taken.
- R5: During reception, an edge f at which `rxLine` is 0 after being 1 at the previous edge re-anchors timing, and the next sample is taken at edge f+O.
- R6: If an anchor event falls on a sample edge, that sample is still taken and the next one is at edge f+P+O.
- R7: With `rateFast`=1 the fast period and offset are used, and with 0 the nominal ones. A reload takes the pair selected at the reload edge.
- R8: A 0-to-1 change of `rateFast` during reception is an anchor event, timed with the fast pair under the rules of R5 and R6.
- R9: `frameDone`=1 during reception returns the block to idle at that edge, and no sample is taken at that edge. If the line is still dominant at the next edge, a new frame starts there.
- R10: While idle with `rxLine`=1, no sample is produced, whatever `rateFast` does.
- R11: A 1-to0 change of `rateFast` does not re-anchor. The current countdown completes, and the nominal period applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Receive line, synchronous, 0 = dominant |
| rateFast | input | 1 | 1 selects the fast bit timing |
| frameDone | input | 1 | Return to idle |
| nomPeriod | input | CNT_W | Nominal bit period in cycles |
| nomOffset | input | CNT_W | Nominal sample offset in cycles |
| fastPeriod | input | CNT_W | Fast bit period in cycles |
| fastOffset | input | CNT_W | Fast sample offset in cycles |
| bitValid | output | 1 | One-cycle strobe per sampled bit |
| bitValue | output | 1 | Level of the last sampled bit |

## Verification
A sample edge can coincide with one of three other events: a dominant edge, the rise of the rate select, or the frame-done request. The bench places each of these events exactly on a cycle where a sample is due. It then measures the cycle of the next strobe against P+O, against the fast P+O, or against a fresh start from idle, all computed arithmetically from the anchor cycle. A sweep over small periods and every legal offset fixes the basic schedule beforehand, so that any shift seen in a collision case comes from the priority rule under test.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;

  typedef enum logic {
    SMP_IDLE = 1'b0,
    SMP_RECV = 1'b1
  } smpState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;   // leave idle, load first offset
    logic stop;    // back to idle
    logic anchor;  // re-anchor timing
    logic sample;  // take a bit this edge
  } smpStrobe_t;

endpackage

// File: rtl/can_bs_ctrl.sv
module can_bs_ctrl
  import can_bs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxLine,
  input  logic       rateFast,
  input  logic       frameDone,
  input  logic       cntZero,
  output smpStrobe_t strobe
);

  smpState_e state;
  logic      rxPrev;
  logic      rateQ;
  logic      fallEdge;
  logic      rateRise;

  assign fallEdge = rxPrev & ~rxLine;
  assign rateRise = rateFast & ~rateQ;

  always_comb begin
    strobe = '0;
    unique case (state)
      SMP_IDLE: strobe.start = ~rxLine;
      SMP_RECV: begin
        strobe.stop   = frameDone;
        strobe.sample = ~frameDone & cntZero;
        strobe.anchor = ~frameDone & (fallEdge | rateRise);
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SMP_IDLE;
      rxPrev <= 1'b1;
      rateQ  <= 1'b0;
    end else begin
      rxPrev <= rxLine;
      rateQ  <= rateFast;
      if (strobe.start)
        state <= SMP_RECV;
      else if (strobe.stop)
        state <= SMP_IDLE;
    end
  end

  // R2: a dominant level while idle starts reception
  a_r2_start_on_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SMP_IDLE && !rxLine) |=> (state == SMP_RECV));

  // R9: frame done always lands in idle
  a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SMP_RECV && frameDone) |=> (state == SMP_IDLE));

endmodule

// File: rtl/can_bs_datapath.sv
module can_bs_datapath
  import can_bs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  logic             rateFast,
  input  logic [CNT_W-1:0] nomPeriod,
  input  logic [CNT_W-1:0] nomOffset,
  input  logic [CNT_W-1:0] fastPeriod,
  input  logic [CNT_W-1:0] fastOffset,
  input  smpStrobe_t       strobe,
  output logic             cntZero,
  output logic             bitValid,
  output logic             bitValue
);

  localparam int ACC_W = CNT_W + 1;

  logic [ACC_W-1:0] cnt;
  logic [ACC_W-1:0] cntNext;
  logic [ACC_W-1:0] selPeriod;
  logic [ACC_W-1:0] selOffset;

  assign selPeriod = {1'b0, (rateFast ? fastPeriod : nomPeriod)};
  assign selOffset = {1'b0, (rateFast ? fastOffset : nomOffset)};
  assign cntZero   = (cnt == '0);

  always_comb begin
    cntNext = cnt;
    if (strobe.stop)
      cntNext = '0;
    else if (strobe.start)
      cntNext = selOffset - 1'b1;
    else if (strobe.anchor && strobe.sample)
      cntNext = selPeriod + selOffset - 1'b1;
    else if (strobe.anchor)
      cntNext = selOffset - 1'b1;
    else if (strobe.sample)
      cntNext = selPeriod - 1'b1;
    else if (!cntZero)
      cntNext = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bitValid <= 1'b0;
      bitValue <= 1'b0;
    end else begin
      cnt      <= cntNext;
      bitValid <= strobe.sample;
      if (strobe.sample)
        bitValue <= rxLine;
    end
  end

  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |=> !bitValid);

  // R3: a reload never leaves the counter at zero
  a_r3_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sample |=> (cnt != '0));

  // R4: value only moves with a sample
  a_r4_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.sample |=> $stable(bitValue));

  // R2: every strobe follows an expired countdown
  a_r2_valid_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bitValid) |-> $past(cntZero));

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_bs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  logic             rateFast,
  input  logic             frameDone,
  input  logic [CNT_W-1:0] nomPeriod,
  input  logic [CNT_W-1:0] nomOffset,
  input  logic [CNT_W-1:0] fastPeriod,
  input  logic [CNT_W-1:0] fastOffset,
  output logic             bitValid,
  output logic             bitValue
);

  smpStrobe_t strobe;
  logic       cntZero;

  can_bs_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxLine    (rxLine),
    .rateFast  (rateFast),
    .frameDone (frameDone),
    .cntZero   (cntZero),
    .strobe    (strobe)
  );

  can_bs_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxLine     (rxLine),
    .rateFast   (rateFast),
    .nomPeriod  (nomPeriod),
    .nomOffset  (nomOffset),
    .fastPeriod (fastPeriod),
    .fastOffset (fastOffset),
    .strobe     (strobe),
    .cntZero    (cntZero),
    .bitValid   (bitValid),
    .bitValue   (bitValue)
  );

endmodule

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;

  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxLine = 1'b1;
  logic rateFast = 1'b0;
  logic frameDone = 1'b0;
  logic [CNT_W-1:0] nomPeriod = 12'd8;
  logic [CNT_W-1:0] nomOffset = 12'd5;
  logic [CNT_W-1:0] fastPeriod = 12'd4;
  logic [CNT_W-1:0] fastOffset = 12'd3;
  logic bitValid;
  logic bitValue;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic prevValid = 1'b0;
  int evT[$];
  bit evV[$];
  int expT[$];
  bit expV[$];

  can_bit_sampler #(.CNT_W(CNT_W)) i_can_bit_sampler (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .rateFast(rateFast),
    .frameDone(frameDone), .nomPeriod(nomPeriod), .nomOffset(nomOffset),
    .fastPeriod(fastPeriod), .fastOffset(fastOffset),
    .bitValid(bitValid), .bitValue(bitValue)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Logger; also judges R4 pulse width
  always @(negedge clk) begin
    if (bitValid) begin
      evT.push_back(cyc);
      evV.push_back(bitValue);
      checks++;
      if (prevValid) begin
        errors++;
        $display("FAIL R4 strobe twice in a row at %0d: actual=1 expected=0", cyc);
      end
    end
    prevValid <= bitValid;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic driveAt(input int x);
    while (cyc < x - 1) @(negedge clk);
  endtask

  task automatic startFrame(output int anchor);
    @(negedge clk);
    evT.delete(); evV.delete(); expT.delete(); expV.delete();
    anchor = cyc + 1;
    rxLine = 1'b0;
  endtask

  task automatic finishFrame(input int x);
    driveAt(x);
    rxLine = 1'b1;
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic addExp(input int t, input bit v);
    expT.push_back(t);
    expV.push_back(v);
  endtask

  task automatic checkLog(input string req);
    int n;
    checks++;
    if (evT.size() != expT.size()) begin
      errors++;
      $display("FAIL %s sample count: actual=%0d expected=%0d", req, evT.size(), expT.size());
    end
    n = (evT.size() < expT.size()) ? evT.size() : expT.size();
    for (int i = 0; i < n; i++) begin
      checks++;
      if (evT[i] != expT[i] || evV[i] != expV[i]) begin
        errors++;
        $display("FAIL %s sample %0d: actual=@%0d/%0b expected=@%0d/%0b",
                 req, i, evT[i], evV[i], expT[i], expV[i]);
      end
    end
  endtask

  initial begin
    int a;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (bitValid !== 1'b0 || bitValue !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%0b%0b expected=00", bitValid, bitValue);
    end
    rst_n = 1'b1;
    evT.delete(); evV.delete(); expT.delete(); expV.delete();
    repeat (10) @(negedge clk);
    checkLog("R1");

    // R2, R3: sweep of period and every legal offset
    for (int p = 3; p <= 6; p++) begin
      for (int o = 1; o < p; o++) begin
        nomPeriod = CNT_W'(p);
        nomOffset = CNT_W'(o);
        startFrame(a);
        addExp(a + o, 0);
        addExp(a + o + p, 0);
        addExp(a + o + 2 * p, 0);
        finishFrame(a + o + 2 * p + 1);
        checkLog("R2/R3 sweep");
      end
    end

    nomPeriod = 12'd8;
    nomOffset = 12'd5;

    // R5: dominant edge between samples moves the schedule
    startFrame(a);
    driveAt(a + 7);  rxLine = 1'b1;
    driveAt(a + 9);  rxLine = 1'b0;
    driveAt(a + 20); rxLine = 1'b1;
    addExp(a + 5, 0); addExp(a + 14, 0); addExp(a + 22, 1);
    finishFrame(a + 23);
    checkLog("R5");

    // R6: dominant edge on a sample edge
    startFrame(a);
    driveAt(a + 11); rxLine = 1'b1;
    driveAt(a + 13); rxLine = 1'b0;
    addExp(a + 5, 0); addExp(a + 13, 0); addExp(a + 26, 0);
    finishFrame(a + 27);
    checkLog("R6");

    // R7, R8, R11: rate rise between samples, later fall
    startFrame(a);
    driveAt(a + 7);  rateFast = 1'b1;
    driveAt(a + 19); rateFast = 1'b0;
    addExp(a + 5, 0); addExp(a + 10, 0); addExp(a + 14, 0);
    addExp(a + 18, 0); addExp(a + 22, 0); addExp(a + 30, 0);
    finishFrame(a + 31);
    checkLog("R7/R8/R11");

    // R8: rate rise on a sample edge
    startFrame(a);
    driveAt(a + 5);  rateFast = 1'b1;
    driveAt(a + 17); rateFast = 1'b0;
    addExp(a + 5, 0); addExp(a + 12, 0); addExp(a + 16, 0);
    addExp(a + 20, 0); addExp(a + 28, 0);
    finishFrame(a + 29);
    checkLog("R8 coincident");

    // R9: frame done on a sample edge, line still dominant
    startFrame(a);
    driveAt(a + 13); frameDone = 1'b1;
    @(negedge clk);  frameDone = 1'b0;
    addExp(a + 5, 0); addExp(a + 19, 0); addExp(a + 27, 0);
    finishFrame(a + 28);
    checkLog("R9");

    // R10: idle with recessive line ignores rate toggles
    @(negedge clk);
    evT.delete(); evV.delete(); expT.delete(); expV.delete();
    repeat (5) @(negedge clk);
    rateFast = 1'b1;
    repeat (7) @(negedge clk);
    rateFast = 1'b0;
    repeat (30) @(negedge clk);
    checkLog("R10");

    summary();
    $finish;
  end

endmodule